// File: doc/BRIEF.md
# Page Owner Map Table

Each tile keeps a small fully associative table that records, for recently used virtual pages, which tile's L1 cache holds the page. The table is searched with the virtual page number at the same time as the local L1 and TLB are indexed. Its answer controls what happens to that load or store. If the owner is the local tile, the local L1 and TLB lookups finish as usual. If the owner is another tile, the local lookups are abandoned, the TLB result is dropped even when it is a miss, and a request carrying the virtual page is sent to the owner tile. If no entry matches, the access traps to the operating system, which installs a mapping through the fill port.

An entry can be marked as a read replica. A load may use a replica mapping. A store that hits a replica mapping traps, so the write reaches the single owner instead of the copy. At barriers and lock acquires, software clears every entry with a one-cycle invalidate-all command. The TLB is separate and is not touched by that command. New pages are placed in slots chosen in round-robin order.

Top module: `page_owner_map`

## Requirements
- R1: After reset every entry is invalid, so every lookup, whether a read or a write, reports no hit and traps.
- R2: A lookup that matches no valid entry raises `lk_trap_o`, with `lk_hit_o`, `lk_owner_o`, `lk_local_o`, `lk_abort_o` and `rq_valid_o` all at 0.
- R3: A hit whose owner equals `my_tile_i` raises `lk_local_o` only. `lk_abort_o` and `rq_valid_o` stay at 0 and `lk_owner_o` shows the owner.
- R4: A hit whose owner differs from `my_tile_i` raises `lk_abort_o` and `rq_valid_o` in the same cycle, with `rq_vpn_o` equal to the looked-up virtual page and `rq_dest_o` equal to the owner. When no request is made, `rq_vpn_o` and `rq_dest_o` are 0.
- R5: A read that hits a replica entry is steered by that entry's owner as in R3 or R4. A write that hits a replica entry sets `lk_hit_o` and raises `lk_trap_o`, with no local proceed and no request.
- R6: A lookup and a fill in the same cycle: the lookup sees the table as it was before the fill. The new mapping is visible from the next cycle on.
- R7: While `inv_all_i` is high, a lookup reports a miss. From the next cycle every entry is invalid. A fill given in the same cycle as `inv_all_i` is dropped.
- R8: A fill for a page that is already present overwrites that entry's owner and replica flag in place. It takes no new slot and does not move the replacement pointer.
- R9: A fill for a page that is not present writes slot number `ptr`, then `ptr` becomes (ptr+1) mod ENTRIES. Reset and invalidate-all set `ptr` to 0. As a result, the (ENTRIES+1)-th distinct page evicts the oldest one.
- R10: With `lk_valid_i` low, every lookup-side output (`lk_hit_o`, `lk_owner_o`, `lk_local_o`, `lk_abort_o`, `lk_trap_o`, `rq_valid_o`, `rq_vpn_o`, `rq_dest_o`) is 0. With it high, exactly one of `lk_local_o`, `rq_valid_o`, `lk_trap_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| my_tile_i | input | ID_W | ID of this tile |
| lk_valid_i | input | 1 | A load or store lookup is present this cycle |
| lk_vpn_i | input | VPN_W | Virtual page number of the access |
| lk_write_i | input | 1 | 1 for a store, 0 for a load |
| lk_hit_o | output | 1 | A valid entry matched |
| lk_owner_o | output | ID_W | Owner tile of the matched entry, 0 on a miss |
| lk_local_o | output | 1 | Let the local L1 and TLB lookups complete |
| lk_abort_o | output | 1 | Abandon the local L1 lookup and drop the TLB result |
| lk_trap_o | output | 1 | Trap to the OS: miss, or a write through a replica |
| rq_valid_o | output | 1 | Send a remote request this cycle |
| rq_vpn_o | output | VPN_W | Virtual page carried by the request |
| rq_dest_o | output | ID_W | Destination tile of the request |
| fill_valid_i | input | 1 | Install a mapping |
| fill_vpn_i | input | VPN_W | Page to install |
| fill_owner_i | input | ID_W | Owner tile to record |
| fill_replica_i | input | 1 | Mark the mapping as a read replica |
| inv_all_i | input | 1 | Clear every entry |

## Verification
The whole virtual page space is swept with both reads and writes at several points. The first sweep runs after reset. Later sweeps run after filling local, remote and replica mappings, after overflowing the table, and after invalidate-all. These sweeps separate the local, remote and trap outcomes, and they show that non-matching pages stay unaffected. Targeted cycles put a fill and a lookup of the same page in one cycle, put a fill in the same cycle as invalidate-all, and refill a page that is already present. Each of these separates the old table contents from the new, and an in-place update from an allocation. A final run of pseudo-random fills, lookups and invalidations, checked against an arithmetic model of slot allocation, catches any drift in the round-robin pointer.

// File: rtl/pom_pkg.sv
package pom_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_LOCAL  = 2'd1,
    DEC_REMOTE = 2'd2,
    DEC_TRAP   = 2'd3
  } pom_dec_e;

  // Outcome of one lookup from match facts.
  function automatic pom_dec_e pom_decide(input logic req, input logic hit,
                                          input logic own_local, input logic wr,
                                          input logic rep);
    if (!req) return DEC_IDLE;
    if (!hit || (wr && rep)) return DEC_TRAP;
    if (own_local) return DEC_LOCAL;
    return DEC_REMOTE;
  endfunction

  // Round-robin successor of slot p in a table of n slots.
  function automatic int unsigned pom_wrap_inc(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/pom_victim_ptr.sv
module pom_victim_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  import pom_pkg::*;

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (adv_i)   ptr_q <= IDX_W'(pom_wrap_inc(32'(ptr_q), ENTRIES));
  end

  assign ptr_o = ptr_q;

  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> ptr_q == '0);
  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clear_i && ptr_q == IDX_W'(ENTRIES-1)) |=> ptr_q == '0);
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clear_i) |=> $stable(ptr_q));
endmodule

// File: rtl/pom_entry_array.sv
module pom_entry_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ID_W    = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [ID_W-1:0]    wr_owner_i,
  input  logic               wr_rep_i,
  input  logic [VPN_W-1:0]   rd_vpn_i,
  output logic               rd_hit_o,
  output logic [ID_W-1:0]    rd_owner_o,
  output logic               rd_rep_o,
  output logic               fl_hit_o,
  output logic [IDX_W-1:0]   fl_idx_o,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [ID_W-1:0]    own_q [ENTRIES];
  logic [ENTRIES-1:0] rep_q;
  logic [ENTRIES-1:0] rd_match, fl_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign rd_match[g] = vld_q[g] && (vpn_q[g] == rd_vpn_i);
    assign fl_match[g] = vld_q[g] && (vpn_q[g] == wr_vpn_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        vpn_q[g] <= '0;
        own_q[g] <= '0;
        rep_q[g] <= 1'b0;
      end else if (inv_i) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        vpn_q[g] <= wr_vpn_i;
        own_q[g] <= wr_owner_i;
        rep_q[g] <= wr_rep_i;
      end
    end
  end

  always_comb begin
    rd_owner_o = '0;
    rd_rep_o   = 1'b0;
    fl_idx_o   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_match[i]) begin
        rd_owner_o = own_q[i];
        rd_rep_o   = rep_q[i];
      end
      if (fl_match[i]) fl_idx_o = IDX_W'(i);
    end
  end

  assign rd_hit_o = |rd_match;
  assign fl_hit_o = |fl_match;
  assign valid_o  = vld_q;

  // R7
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> vld_q == '0);
  // R8
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_match));
endmodule

// File: rtl/page_owner_map.sv
module page_owner_map #(
  parameter int VPN_W   = 20,
  parameter int TILES   = 16,
  parameter int ENTRIES = 8,
  localparam int ID_W  = (TILES > 1) ? $clog2(TILES) : 1,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  my_tile_i,
  input  logic             lk_valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_write_i,
  output logic             lk_hit_o,
  output logic [ID_W-1:0]  lk_owner_o,
  output logic             lk_local_o,
  output logic             lk_abort_o,
  output logic             lk_trap_o,
  output logic             rq_valid_o,
  output logic [VPN_W-1:0] rq_vpn_o,
  output logic [ID_W-1:0]  rq_dest_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [ID_W-1:0]  fill_owner_i,
  input  logic             fill_replica_i,
  input  logic             inv_all_i
);
  import pom_pkg::*;

  logic               arr_hit, arr_rep, fl_hit, fill_go, alloc_go;
  logic [ID_W-1:0]    arr_owner;
  logic [IDX_W-1:0]   fl_idx, victim, wr_idx;
  logic [ENTRIES-1:0] valid_vec;
  logic               hit_eff;
  pom_dec_e           dec;

  assign fill_go  = fill_valid_i && !inv_all_i;
  assign alloc_go = fill_go && !fl_hit;
  assign wr_idx   = fl_hit ? fl_idx : victim;

  pom_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear_i(inv_all_i), .adv_i(alloc_go), .ptr_o(victim)
  );

  pom_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ID_W(ID_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .inv_i(inv_all_i),
    .wr_en_i(fill_go), .wr_idx_i(wr_idx), .wr_vpn_i(fill_vpn_i),
    .wr_owner_i(fill_owner_i), .wr_rep_i(fill_replica_i),
    .rd_vpn_i(lk_vpn_i), .rd_hit_o(arr_hit), .rd_owner_o(arr_owner), .rd_rep_o(arr_rep),
    .fl_hit_o(fl_hit), .fl_idx_o(fl_idx), .valid_o(valid_vec)
  );

  assign hit_eff = arr_hit && !inv_all_i;
  assign dec = pom_decide(lk_valid_i, hit_eff, arr_owner == my_tile_i, lk_write_i, arr_rep);

  assign lk_hit_o   = lk_valid_i && hit_eff;
  assign lk_owner_o = lk_hit_o ? arr_owner : '0;
  assign lk_local_o = (dec == DEC_LOCAL);
  assign rq_valid_o = (dec == DEC_REMOTE);
  assign lk_abort_o = rq_valid_o;
  assign lk_trap_o  = (dec == DEC_TRAP);
  assign rq_vpn_o   = rq_valid_o ? lk_vpn_i : '0;
  assign rq_dest_o  = rq_valid_o ? arr_owner : '0;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |-> $countones({lk_local_o, rq_valid_o, lk_trap_o}) == 1);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |-> !(lk_hit_o || lk_local_o || rq_valid_o || lk_trap_o || lk_abort_o));
  // R4
  remote_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o |-> (rq_dest_o != my_tile_i && lk_abort_o && rq_vpn_o == lk_vpn_i));
  // R5
  replica_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && lk_write_i && hit_eff && arr_rep) |-> lk_trap_o);
  // R7
  inv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_i |-> !lk_hit_o);
  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> valid_vec == '0);
endmodule

// File: tb/tb_page_owner_map.sv
module tb_page_owner_map;
  localparam int VW = 6, NT = 4, NE = 4, IW = 2;
  localparam logic [IW-1:0] ME = 2'd2;

  logic clk = 0, rst_n = 0;
  logic lk_valid, lk_write, fill_valid, fill_rep, inv_all;
  logic [VW-1:0] lk_vpn, fill_vpn, rq_vpn;
  logic [IW-1:0] fill_own, lk_owner, rq_dest;
  logic lk_hit, lk_local, lk_abort, lk_trap, rq_valid;

  page_owner_map #(.VPN_W(VW), .TILES(NT), .ENTRIES(NE)) dut (
    .clk(clk), .rst_n(rst_n), .my_tile_i(ME),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_write_i(lk_write),
    .lk_hit_o(lk_hit), .lk_owner_o(lk_owner), .lk_local_o(lk_local),
    .lk_abort_o(lk_abort), .lk_trap_o(lk_trap), .rq_valid_o(rq_valid),
    .rq_vpn_o(rq_vpn), .rq_dest_o(rq_dest),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_owner_i(fill_own),
    .fill_replica_i(fill_rep), .inv_all_i(inv_all)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string ctx = "R1";

  bit m_v[NE]; int m_vpn[NE]; int m_own[NE]; bit m_rep[NE]; int m_ptr = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s/%s %s: actual %0d expected %0d", ctx, tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit lv, int vpn, bit wr, bit fv, int fvpn, int fown, bit frep, bit inv);
    bit h, rp, loc, rem, trp; int own; string tag; bit found;
    @(negedge clk);
    lk_valid = lv; lk_vpn = VW'(vpn); lk_write = wr;
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_own = IW'(fown); fill_rep = frep; inv_all = inv;
    #1;
    h = 0; own = 0; rp = 0;
    for (int i = 0; i < NE; i++)
      if (m_v[i] && m_vpn[i] == vpn) begin h = 1; own = m_own[i]; rp = m_rep[i]; end
    if (inv || !lv) h = 0;
    trp = lv && (!h || (wr && rp));
    loc = lv && !trp && own == int'(ME);
    rem = lv && !trp && own != int'(ME);
    tag = !lv ? "R10" : inv ? "R7" : (trp && h) ? "R5" : trp ? "R2" : loc ? "R3" : "R4";
    chk(tag, "hit", lk_hit, h);
    chk(tag, "owner", lk_owner, h ? own : 0);
    chk(tag, "local", lk_local, loc);
    chk(tag, "abort", lk_abort, rem);
    chk(tag, "trap", lk_trap, trp);
    chk(tag, "rq_valid", rq_valid, rem);
    chk(tag, "rq_vpn", rq_vpn, rem ? vpn : 0);
    chk(tag, "rq_dest", rq_dest, rem ? own : 0);
    @(posedge clk); #1;
    if (inv) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (fv) begin
      found = 0;
      for (int i = 0; i < NE; i++)
        if (m_v[i] && m_vpn[i] == fvpn) begin found = 1; m_own[i] = fown; m_rep[i] = frep; end
      if (!found) begin
        m_v[m_ptr] = 1; m_vpn[m_ptr] = fvpn; m_own[m_ptr] = fown; m_rep[m_ptr] = frep;
        m_ptr = (m_ptr + 1) % NE;
      end
    end
  endtask

  task automatic fill(int vpn, int own, bit rep);
    cyc(0, 0, 0, 1, vpn, own, rep, 0);
  endtask

  task automatic sweep();
    for (int v = 0; v < (1 << VW); v++) begin
      cyc(1, v, 0, 0, 0, 0, 0, 0);
      cyc(1, v, 1, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int x;
    lk_valid = 0; lk_vpn = 0; lk_write = 0; fill_valid = 0; fill_vpn = 0;
    fill_own = 0; fill_rep = 0; inv_all = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    ctx = "R1"; sweep();
    ctx = "R10"; cyc(0, 5, 1, 0, 0, 0, 0, 0);
    ctx = "R3R4R5";
    fill(10, 2, 0); fill(11, 0, 0); fill(12, 3, 0); fill(13, 2, 1);
    sweep();
    ctx = "R5"; fill(12, 3, 1); cyc(1, 12, 0, 0, 0, 0, 0, 0); cyc(1, 12, 1, 0, 0, 0, 0, 0);
    ctx = "R6"; cyc(1, 20, 0, 1, 20, 1, 0, 0); cyc(1, 20, 0, 0, 0, 0, 0, 0);
    ctx = "R9"; sweep();
    ctx = "R8"; fill(11, 2, 0); fill(30, 1, 0); sweep();
    ctx = "R7"; cyc(1, 30, 0, 1, 40, 3, 0, 1); sweep();
    ctx = "R9"; for (int k = 0; k < 2 * NE + 1; k++) fill(k * 3, k % NT, k[0]); sweep();
    ctx = "R9"; x = 7;
    for (int k = 0; k < 3000; k++) begin
      x = x * 1103515245 + 12345;
      cyc(x[20], x[13:8] % 12, x[21], x[22], x[29:24] % 12, x[31:30], x[23], x[19:12] == 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule